// File: doc/BRIEF.md
# Cascaded 96-Source Interrupt Controller

This block gathers 96 interrupt sources into one CPU interrupt line and a numbered vector. Sources 0–31 come from a low main cause word and sources 32–63 from a high main cause word. Both words are sampled each cycle from raw level vectors that stand in for on-chip units. Sources 64–95 come from 32 external port pins. The pins are synchronised and edge-detected, and each rising edge latches a bit in a port cause word. Four bits of the high main word are not raw inputs. Each is a summary of one 8-bit slice of the enabled port cause bits, so the port word sits one level below the main words.

Each of the three groups has its own 32-bit enable mask. The encoder first searches the low main word, then the high main word, with a fixed filter that keeps unimplemented bits out. If the winning high bit is a port summary, the encoder descends into the port word. The lowest qualifying source becomes the vector, or "no valid vector" if none qualifies. Software reaches the cause and mask words over a small register bus. An acknowledge of a port vector clears that port bit.

Top module: `intc_cascade`

## Requirements
- R1: After reset the low and port masks read 0, the high mask reads 0x0F000000, the port cause word reads 0, and both `vec_valid` and `cpu_irq` are low.
- R2: The reported vector is the lowest enabled pending source. A qualifying low-word bit n gives vector n and always beats the high word. A high-word bit m that qualifies and is not a summary gives vector 32+m and beats the port word.
- R3: Low main cause bits 0, 25, 30 and 31 never win arbitration (implemented-bit filter 0x3DFFFFFE).
- R4: Only high main cause bits 0, 1, 2, 4, 5, 7, 8, 10, 11 and 24–27 can win (filter 0x0F000DB7).
- R5: High main cause bit 24+k (k = 0..3) reads as the OR of port cause AND port mask over port bits 8k..8k+7. The raw input bits 24–27 of the high source vector are ignored.
- R6: When a port summary bit wins, the vector is 64 plus the lowest set bit of port cause AND port mask.
- R7: With no qualifying source, `vec_valid` is low.
- R8: A bus write to the port cause word (address 2) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R9: A rising edge on `port_pin[i]` sets port cause bit i after a two-flop synchroniser. A pin held high does not set the bit again once it is cleared.
- R10: When a pin edge and a zero-write clear hit the same port bit in the same cycle, the bit ends up set.
- R11: An acknowledge pulse while a port vector 64+i is valid clears port cause bit i.
- R12: A write to address 6 enables, and a write to address 7 disables, the single source whose number is in `bus_wdata[6:0]`. Numbers 96 and above change no mask.
- R13: `cpu_irq` is high exactly when `vec_valid` is high. Both come from a single register stage after the encoder.
- R14: Full-word writes to addresses 3, 4 and 5 load the low, high and port masks. Reads of addresses 0–5 return the low cause, high cause view, port cause, and the three masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_lo_src | input | 32 | Raw level sources 0–31 |
| main_hi_src | input | 32 | Raw level sources 32–63 (bits 24–27 ignored) |
| port_pin | input | 32 | Asynchronous external port pins |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe (with select) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| vec_ack | input | 1 | Vector acknowledge pulse |
| vec_valid | output | 1 | Vector holds a valid source |
| vec_id | output | 7 | Source number 0–95 |
| cpu_irq | output | 1 | CPU interrupt line |

## Verification
The bench builds the controller with its default parameters: two synchroniser stages and the two implemented-bit filters. The short synchroniser makes the cycle in which a pin edge lands predictable, so a bench can place a zero-write clear on that same edge. The default filters include unimplemented bits at both ends of the low word and scattered holes in the high word. Random cause patterns therefore hit filtered bits often, alongside the summary descent into the port word.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_SRC = 96;
  localparam int VEC_W   = 7;
  localparam int ADDR_W  = 3;
  localparam int N_SUMM  = 4;
  localparam int SLICE_W = WORD_W / 8 * 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CAUSE_LO = 3'd0,
    RA_CAUSE_HI = 3'd1,
    RA_PORT_CS  = 3'd2,
    RA_MASK_LO  = 3'd3,
    RA_MASK_HI  = 3'd4,
    RA_MASK_PT  = 3'd5,
    RA_EN_NUM   = 3'd6,
    RA_DIS_NUM  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic       hit;
    logic [4:0] idx;
  } pick_t;

  function automatic pick_t pick_lowest(input logic [WORD_W-1:0] v);
    pick_t r;
    r = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.hit = 1'b1;
        r.idx = i[4:0];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/intc_port_edge.sv
module intc_port_edge #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= pin;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter logic [WORD_W-1:0] HI_MASK_RST = 32'h0F00_0000,
  parameter int                SUMM_LSB    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] lo_src,
  input  logic [WORD_W-1:0] hi_src,
  input  logic [WORD_W-1:0] rise,
  input  logic [WORD_W-1:0] ack_clr,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] cause_lo,
  output logic [WORD_W-1:0] cause_hi,
  output logic [WORD_W-1:0] port_cause,
  output logic [WORD_W-1:0] mask_lo,
  output logic [WORD_W-1:0] mask_hi,
  output logic [WORD_W-1:0] mask_port
);
  localparam int SW = WORD_W / N_SUMM;

  logic [WORD_W-1:0] lo_q, hi_q;
  logic [WORD_W-1:0] pc_q, pc_n;
  logic [WORD_W-1:0] mlo_q, mlo_n, mhi_q, mhi_n, mpt_q, mpt_n;
  logic [N_SUMM-1:0] summ;
  logic [WORD_W-1:0] pc_en;
  logic              wr_hit;
  logic [VEC_W-1:0]  num;
  logic              unused_hi_bits;

  assign unused_hi_bits = ^hi_q[SUMM_LSB +: N_SUMM];
  assign pc_en  = pc_q & mpt_q;
  assign wr_hit = bus_sel & bus_wr;
  assign num    = bus_wdata[VEC_W-1:0];

  for (genvar k = 0; k < N_SUMM; k++) begin : g_summ
    assign summ[k] = |pc_en[k*SW +: SW];
  end

  always_comb begin
    cause_hi = hi_q;
    cause_hi[SUMM_LSB +: N_SUMM] = summ;
  end

  always_comb begin
    pc_n  = pc_q & ~ack_clr;
    mlo_n = mlo_q;
    mhi_n = mhi_q;
    mpt_n = mpt_q;
    if (wr_hit) begin
      case (reg_addr_e'(bus_addr))
        RA_PORT_CS: pc_n  = pc_n & bus_wdata;
        RA_MASK_LO: mlo_n = bus_wdata;
        RA_MASK_HI: mhi_n = bus_wdata;
        RA_MASK_PT: mpt_n = bus_wdata;
        RA_EN_NUM, RA_DIS_NUM: begin
          if (num < 7'd32)      mlo_n[num[4:0]] = (bus_addr == RA_EN_NUM);
          else if (num < 7'd64) mhi_n[num[4:0]] = (bus_addr == RA_EN_NUM);
          else if (num < 7'd96) mpt_n[num[4:0]] = (bus_addr == RA_EN_NUM);
        end
        default: ;
      endcase
    end
    pc_n = pc_n | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      pc_q  <= '0;
      mlo_q <= '0;
      mhi_q <= HI_MASK_RST;
      mpt_q <= '0;
    end else begin
      lo_q  <= lo_src;
      hi_q  <= hi_src;
      pc_q  <= pc_n;
      mlo_q <= mlo_n;
      mhi_q <= mhi_n;
      mpt_q <= mpt_n;
    end
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      RA_CAUSE_LO: bus_rdata = lo_q;
      RA_CAUSE_HI: bus_rdata = cause_hi;
      RA_PORT_CS:  bus_rdata = pc_q;
      RA_MASK_LO:  bus_rdata = mlo_q;
      RA_MASK_HI:  bus_rdata = mhi_q;
      RA_MASK_PT:  bus_rdata = mpt_q;
      default:     bus_rdata = '0;
    endcase
  end

  assign cause_lo   = lo_q;
  assign port_cause = pc_q;
  assign mask_lo    = mlo_q;
  assign mask_hi    = mhi_q;
  assign mask_port  = mpt_q;

  // A port bit may only appear where an edge was seen the cycle before.
  assert_no_spont_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pc_q & ~$past(pc_q) & ~$past(rise)) == '0));

  // An edge always lands, whatever clear runs alongside it.
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pc_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/intc_encoder.sv
module intc_encoder
  import intc_pkg::*;
#(
  parameter logic [WORD_W-1:0] LO_FILT  = 32'h3DFF_FFFE,
  parameter logic [WORD_W-1:0] HI_FILT  = 32'h0F00_0DB7,
  parameter int                SUMM_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cause_lo,
  input  logic [WORD_W-1:0] cause_hi,
  input  logic [WORD_W-1:0] port_cause,
  input  logic [WORD_W-1:0] mask_lo,
  input  logic [WORD_W-1:0] mask_hi,
  input  logic [WORD_W-1:0] mask_port,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_id,
  output logic              cpu_irq
);
  pick_t            p_lo, p_hi, p_pt;
  logic             val_n, val_q, irq_q;
  logic [VEC_W-1:0] id_n, id_q;

  always_comb begin
    p_lo  = pick_lowest(cause_lo & LO_FILT & mask_lo);
    p_hi  = pick_lowest(cause_hi & HI_FILT & mask_hi);
    p_pt  = pick_lowest(port_cause & mask_port);
    val_n = 1'b0;
    id_n  = '0;
    if (p_lo.hit) begin
      val_n = 1'b1;
      id_n  = {2'b00, p_lo.idx};
    end else if (p_hi.hit) begin
      if (32'(p_hi.idx) >= SUMM_LSB) begin
        val_n = p_pt.hit;
        id_n  = p_pt.hit ? {2'b10, p_pt.idx} : '0;
      end else begin
        val_n = 1'b1;
        id_n  = {2'b01, p_hi.idx};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0;
      irq_q <= 1'b0;
      id_q  <= '0;
    end else begin
      val_q <= val_n;
      irq_q <= val_n;
      id_q  <= id_n;
    end
  end

  assign vec_valid = val_q;
  assign vec_id    = id_q;
  assign cpu_irq   = irq_q;

  assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_id < 7'(NUM_SRC)));

  assert_lo_filter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_id[6:5] == 2'b00) |-> LO_FILT[vec_id[4:0]]);

  assert_hi_filter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_id[6:5] == 2'b01) |->
      (HI_FILT[vec_id[4:0]] && 32'(vec_id[4:0]) < SUMM_LSB));

  assert_irq_tracks_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == vec_valid);
endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
  import intc_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] LO_FILT     = 32'h3DFF_FFFE,
  parameter logic [WORD_W-1:0] HI_FILT     = 32'h0F00_0DB7,
  parameter int                SUMM_LSB    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] main_lo_src,
  input  logic [WORD_W-1:0] main_hi_src,
  input  logic [WORD_W-1:0] port_pin,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              vec_ack,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_id,
  output logic              cpu_irq
);
  localparam logic [WORD_W-1:0] HI_MASK_RST =
    WORD_W'(((1 << N_SUMM) - 1) << SUMM_LSB);

  logic [WORD_W-1:0] rise, ack_clr;
  logic [WORD_W-1:0] c_lo, c_hi, c_pt, m_lo, m_hi, m_pt;

  always_comb begin
    ack_clr = '0;
    if (vec_ack && vec_valid && vec_id[6:5] == 2'b10) ack_clr[vec_id[4:0]] = 1'b1;
  end

  intc_port_edge #(.N(WORD_W), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(port_pin), .rise(rise)
  );

  intc_regs #(.HI_MASK_RST(HI_MASK_RST), .SUMM_LSB(SUMM_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .lo_src(main_lo_src), .hi_src(main_hi_src),
    .rise(rise), .ack_clr(ack_clr), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cause_lo(c_lo), .cause_hi(c_hi), .port_cause(c_pt),
    .mask_lo(m_lo), .mask_hi(m_hi), .mask_port(m_pt)
  );

  intc_encoder #(.LO_FILT(LO_FILT), .HI_FILT(HI_FILT), .SUMM_LSB(SUMM_LSB)) u_enc (
    .clk(clk), .rst_n(rst_n), .cause_lo(c_lo), .cause_hi(c_hi),
    .port_cause(c_pt), .mask_lo(m_lo), .mask_hi(m_hi), .mask_port(m_pt),
    .vec_valid(vec_valid), .vec_id(vec_id), .cpu_irq(cpu_irq)
  );
endmodule

// File: tb/intc_cascade_test.sv
module intc_cascade_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] main_lo_src, main_hi_src, port_pin, bus_wdata, bus_rdata;
  logic        bus_sel, bus_wr, vec_ack, vec_valid, cpu_irq;
  logic [2:0]  bus_addr;
  logic [6:0]  vec_id;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] m_lo, m_hi, m_pt, pc;

  localparam logic [31:0] F_LO = 32'h3DFF_FFFE;
  localparam logic [31:0] F_HI = 32'h0F00_0DB7;

  always #2 clk = ~clk;

  intc_cascade uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic int low_bit(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] hi_view();
    logic [31:0] h = main_hi_src;
    logic [31:0] e = pc & m_pt;
    for (int k = 0; k < 4; k++) h[24+k] = |e[8*k +: 8];
    return h;
  endfunction

  // expected vector: -1 when nothing valid
  function automatic int exp_vec();
    int a, b, c;
    a = low_bit(main_lo_src & F_LO & m_lo);
    if (a >= 0) return a;
    b = low_bit(hi_view() & F_HI & m_hi);
    if (b < 0) return -1;
    if (b < 24) return 32 + b;
    c = low_bit(pc & m_pt);
    return (c < 0) ? -1 : 64 + c;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic pulse_pin(input int i);
    @(negedge clk);
    port_pin[i] = 1'b1;
    cyc(4);
    port_pin[i] = 1'b0;
    pc[i] = 1'b1;
  endtask

  task automatic check_vec(input string req);
    int e;
    cyc(6);
    e = exp_vec();
    chk(vec_valid == (e >= 0) && (e < 0 || vec_id == 7'(e)), req,
        {vec_valid, 24'd0, vec_id}, (e < 0) ? 32'd0 : {1'b1, 24'd0, 7'(e)});
    chk(cpu_irq == (e >= 0), "R13", {31'd0, cpu_irq}, {31'd0, 1'(e >= 0)});
  endtask

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd7091));
    rst_n = 0; main_lo_src = 0; main_hi_src = 0; port_pin = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; vec_ack = 0;
    m_lo = 0; m_hi = 32'h0F00_0000; m_pt = 0; pc = 0;
    cyc(3);
    rst_n = 1;
    cyc(2);

    // R1 reset state
    bread(3'd3, rd); chk(rd == 0, "R1", rd, 0);
    bread(3'd4, rd); chk(rd == 32'h0F00_0000, "R1", rd, 32'h0F00_0000);
    bread(3'd5, rd); chk(rd == 0, "R1", rd, 0);
    bread(3'd2, rd); chk(rd == 0, "R1", rd, 0);
    chk(!vec_valid && !cpu_irq, "R1", {vec_valid, cpu_irq}, 0);

    // R14 full mask writes
    bwrite(3'd3, 32'hFFFF_FFFF); m_lo = 32'hFFFF_FFFF;
    bwrite(3'd4, 32'hFFFF_FFFF); m_hi = 32'hFFFF_FFFF;
    bread(3'd4, rd); chk(rd == 32'hFFFF_FFFF, "R14", rd, 32'hFFFF_FFFF);

    // R3 filtered low bits never win
    main_lo_src = 32'hC200_0001;
    check_vec("R3");
    chk(!vec_valid, "R3", {31'd0, vec_valid}, 0);
    main_lo_src = 32'hC200_0001 | (1 << 7);
    check_vec("R3");

    // R4 filtered high bits
    main_lo_src = 0; main_hi_src = 32'h0000_0248;
    check_vec("R4");
    chk(!vec_valid, "R4", {31'd0, vec_valid}, 0);
    main_hi_src = 32'h0000_0800;
    check_vec("R4");
    chk(vec_id == 7'd43, "R4", {25'd0, vec_id}, 43);

    // R2 low beats high
    main_lo_src = 32'h0000_0020; main_hi_src = 32'h0000_0001;
    check_vec("R2");
    chk(vec_id == 7'd5, "R2", {25'd0, vec_id}, 5);
    main_lo_src = 0;

    // R12 enable by number, out-of-range ignored
    bwrite(3'd6, 32'd100);
    bread(3'd5, rd); chk(rd == 0, "R12", rd, 0);
    bwrite(3'd6, 32'd70); m_pt[6] = 1;
    bread(3'd5, rd); chk(rd == 32'h40, "R12", rd, 32'h40);
    bwrite(3'd7, 32'd33); m_hi[1] = 0;
    bread(3'd4, rd); chk(rd == 32'hFFFF_FFFD, "R12", rd, 32'hFFFF_FFFD);
    bwrite(3'd7, 32'd127);
    bread(3'd3, rd); chk(rd == 32'hFFFF_FFFF, "R12", rd, 32'hFFFF_FFFF);

    // R9 / R6 / R5 port cascade
    main_hi_src = 32'h0F00_0000;
    pulse_pin(6);
    cyc(3);
    bread(3'd2, rd); chk(rd == 32'h40, "R9", rd, 32'h40);
    bread(3'd1, rd); chk(rd == 32'h0100_0000, "R5", rd, 32'h0100_0000);
    main_hi_src = 0;
    check_vec("R6");
    chk(vec_id == 7'd70, "R6", {25'd0, vec_id}, 70);

    // R11 acknowledge clears port bit
    @(negedge clk); vec_ack = 1; @(negedge clk); vec_ack = 0; pc[6] = 0;
    cyc(2);
    bread(3'd2, rd); chk(rd == 0, "R11", rd, 0);
    check_vec("R7");

    // R10 edge and zero-write on same cycle
    pulse_pin(3);
    cyc(3);
    @(negedge clk); port_pin[9] = 1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd2; bus_wdata = 0;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    pc = 32'h200;
    bread(3'd2, rd); chk(rd == 32'h200, "R10", rd, 32'h200);
    // R9 pin still high: no re-set after clear
    bwrite(3'd2, 32'h0); pc = 0;
    cyc(5);
    bread(3'd2, rd); chk(rd == 0, "R9", rd, 0);
    port_pin[9] = 0;
    cyc(4);

    // R8 write-zero clear keeps ones
    pulse_pin(1); pulse_pin(17);
    cyc(3);
    bwrite(3'd2, 32'hFFFF_FFFD); pc[1] = 0;
    bread(3'd2, rd); chk(rd == 32'h0002_0000, "R8", rd, 32'h0002_0000);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int act = $urandom_range(0, 5);
      case (act)
        0: begin
          main_lo_src = $urandom & $urandom & $urandom;
          main_hi_src = $urandom & $urandom;
        end
        1: begin
          logic [31:0] v = $urandom;
          logic [2:0]  a = 3'(3 + $urandom_range(0, 2));
          bwrite(a, v);
          if (a == 3) m_lo = v; else if (a == 4) m_hi = v; else m_pt = v;
        end
        2: pulse_pin($urandom_range(0, 31));
        3: begin
          logic [31:0] v = $urandom | $urandom;
          bwrite(3'd2, v); pc &= v;
        end
        4: begin
          int e = exp_vec();
          cyc(6);
          @(negedge clk); vec_ack = 1; @(negedge clk); vec_ack = 0;
          if (e >= 64) pc[e-64] = 0;
        end
        default: begin
          int n = $urandom_range(0, 99);
          bit en = 1'($urandom);
          bwrite(en ? 3'd6 : 3'd7, 32'(n));
          if (n < 32) m_lo[n] = en;
          else if (n < 64) m_hi[n-32] = en;
          else if (n < 96) m_pt[n-64] = en;
        end
      endcase
      check_vec("R2");
      if (it % 8 == 0) begin
        cyc(2);
        bread(3'd2, rd); chk(rd == pc, "R8", rd, pc);
        bread(3'd1, rd); chk(rd == hi_view(), "R5", rd, hi_view());
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule